// File: doc/BRIEF.md
# Clocked Pulse-Handshake Sequencer

This block runs a chain of child processes strictly one after another, on behalf of a single parent. Every event on every wire is one clock cycle of logic high. A cycle with the wire low carries no event. When the parent pulses its request, the block starts child 0. When child 0 acknowledges, the block starts child 1, and so on. When the last child acknowledges, the block acknowledges the parent and returns to idle.

Each forwarding step goes through one register. An input event in cycle n therefore appears as an output event in cycle n+1, and no path runs combinationally from any input to any output. The number of children is a parameter; the default is two.

Any input pulse that the current state does not expect is a protocol violation. Such a pulse is ignored and sets a sticky error flag, which only reset clears.

Top module: `pulse_seq`

## Requirements
- R1: A synchronous active-high reset drives every child request, the parent acknowledge and the error flag low at the next clock edge, and returns the block to idle.
- R2: A parent request pulse received while idle in cycle n produces a pulse on child request bit 0 in cycle n+1.
- R3: An accepted acknowledge from child k, where k is not the last child, received in cycle m produces a pulse on child request bit k+1 in cycle m+1.
- R4: An accepted acknowledge from the last child received in cycle m produces a parent acknowledge pulse in cycle m+1, and the block is then idle.
- R5: In any cycle at most one of the outputs (child request bits and parent acknowledge) is high, and each output pulse lasts exactly one cycle.
- R6: A parent request that arrives while a child is still running is a violation. It sets the error output one cycle later and starts nothing.
- R7: An acknowledge from any child other than the one awaited, including any acknowledge while idle, is a violation. It sets the error output one cycle later and changes no output.
- R8: An acknowledge from the awaited child in the same cycle as that child's request pulse is a violation. It is ignored, and the child must acknowledge again in a later cycle.
- R9: Once set, the error output stays high through any further traffic until reset.
- R10: A parent request in the same cycle as the parent acknowledge pulse is accepted as a fresh start, so child request bit 0 pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| parent_req_i | input | 1 | Start pulse from the parent |
| parent_ack_o | output | 1 | Completion pulse to the parent |
| child_req_o | output | NUM_CHILD | Start pulse to each child, bit k for child k |
| child_ack_i | input | NUM_CHILD | Completion pulse from each child, bit k for child k |
| err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The properties assume that each input is a single-cycle pulse sampled at the rising edge. They also assume that children answer no earlier than the cycle after their request. The forwarding properties only look one cycle back, so they hold whatever the environment does. The stimulus uses child models with random latency between one and four cycles and random gaps between parent requests, including back-to-back requests. It departs from the protocol only in deliberate injections: an extra parent request, an acknowledge from the wrong child, an acknowledge in the same cycle as the request, and an acknowledge while idle. For each injection the bench expects the error flag at the exact next cycle and expects the sequence to be otherwise unaffected.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    // Width of the child index; NUM_CHILD must not exceed 2**IDX_W.
    localparam int IDX_W = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;   // child currently awaited
    } seq_st_t;

    function automatic logic [IDX_W-1:0] idx_of(input int k);
        return IDX_W'(k);
    endfunction

endpackage

// File: rtl/pseq_stage.sv
module pseq_stage #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // One register per event wire: every hand-off costs exactly one cycle.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[b] <= 1'b0;
            else     q[b] <= d[b];
        end
    end
endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
    import pseq_pkg::*;
#(
    parameter int NUM_CHILD = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 parent_req_i,
    input  logic [NUM_CHILD-1:0] child_ack_i,
    input  logic [NUM_CHILD-1:0] child_req_now_i,
    output logic [NUM_CHILD-1:0] fire_child_o,
    output logic                 fire_done_o,
    output logic                 viol_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CHILD - 1);

    seq_st_t              st_q, st_d;
    logic [NUM_CHILD-1:0] take;
    logic [IDX_W-1:0]     nxt_idx;
    logic                 bad_parent;

    always_comb begin
        st_d         = st_q;
        fire_child_o = '0;
        fire_done_o  = 1'b0;
        take         = '0;
        bad_parent   = 1'b0;
        nxt_idx      = st_q.idx + 1'b1;
        case (st_q.phase)
            PH_IDLE: begin
                if (parent_req_i) begin
                    fire_child_o[0] = 1'b1;
                    st_d.phase      = PH_WAIT;
                    st_d.idx        = '0;
                end
            end
            default: begin
                bad_parent = parent_req_i;
                // Accept only the awaited child, and only once its request pulse is over.
                for (int k = 0; k < NUM_CHILD; k++) begin
                    if (idx_of(k) == st_q.idx && child_ack_i[k] && !child_req_now_i[k])
                        take[k] = 1'b1;
                end
                if (|take) begin
                    if (st_q.idx == LAST) begin
                        fire_done_o = 1'b1;
                        st_d.phase  = PH_IDLE;
                        st_d.idx    = '0;
                    end else begin
                        st_d.idx = nxt_idx;
                        for (int k = 0; k < NUM_CHILD; k++) begin
                            if (idx_of(k) == nxt_idx) fire_child_o[k] = 1'b1;
                        end
                    end
                end
            end
        endcase
        viol_o = bad_parent | (|(child_ack_i & ~take));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pseq_errlat.sv
module pseq_errlat (
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= err_o | viol_i;
    end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import pseq_pkg::*;
#(
    parameter int NUM_CHILD = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 parent_req_i,
    output logic                 parent_ack_o,
    output logic [NUM_CHILD-1:0] child_req_o,
    input  logic [NUM_CHILD-1:0] child_ack_i,
    output logic                 err_o
);
    localparam int SW = NUM_CHILD + 1;

    logic [NUM_CHILD-1:0] fire_child;
    logic                 fire_done;
    logic                 viol;
    logic [SW-1:0]        stage_q;

    pseq_fsm #(.NUM_CHILD(NUM_CHILD)) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .parent_req_i    (parent_req_i),
        .child_ack_i     (child_ack_i),
        .child_req_now_i (child_req_o),
        .fire_child_o    (fire_child),
        .fire_done_o     (fire_done),
        .viol_o          (viol)
    );

    pseq_stage #(.W(SW)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   ({fire_done, fire_child}),
        .q   (stage_q)
    );

    pseq_errlat u_err (
        .clk    (clk),
        .rst    (rst),
        .viol_i (viol),
        .err_o  (err_o)
    );

    assign child_req_o  = stage_q[NUM_CHILD-1:0];
    assign parent_ack_o = stage_q[NUM_CHILD];
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
    parameter int NUM_CHILD = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 parent_req_i,
    input logic                 parent_ack_o,
    input logic [NUM_CHILD-1:0] child_req_o,
    input logic [NUM_CHILD-1:0] child_ack_i,
    input logic                 err_o
);
    p_outs_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({parent_ack_o, child_req_o}));

    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        parent_ack_o |=> !parent_ack_o);

    p_first_req_r2: assert property (@(posedge clk) disable iff (rst)
        child_req_o[0] |-> $past(parent_req_i));

    for (genvar k = 1; k < NUM_CHILD; k++) begin : g_fwd
        p_next_req_r3: assert property (@(posedge clk) disable iff (rst)
            child_req_o[k] |-> $past(child_ack_i[k-1]));
    end

    p_done_r4: assert property (@(posedge clk) disable iff (rst)
        parent_ack_o |-> $past(child_ack_i[NUM_CHILD-1]));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(parent_req_i || (|child_ack_i)));
endmodule

bind pulse_seq pulse_seq_chk #(.NUM_CHILD(NUM_CHILD)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .parent_req_i (parent_req_i),
    .parent_ack_o (parent_ack_o),
    .child_req_o  (child_req_o),
    .child_ack_i  (child_ack_i),
    .err_o        (err_o)
);

// File: tb/pulse_seq_bench.sv
`timescale 1ns/1ps
module pulse_seq_bench;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         parent_req = 1'b0;
    logic [N-1:0] child_ack = '0;
    logic         parent_ack;
    logic [N-1:0] child_req;
    logic         err;

    always #2.5 clk = ~clk;

    pulse_seq #(.NUM_CHILD(N)) u_pulse_seq (
        .clk          (clk),
        .rst          (rst),
        .parent_req_i (parent_req),
        .parent_ack_o (parent_ack),
        .child_req_o  (child_req),
        .child_ack_i  (child_ack),
        .err_o        (err)
    );

    typedef struct {
        int           at;
        logic [N:0]   bits;   // bit N: parent ack, bit k: child k request
    } exp_t;

    exp_t  sbq[$];
    int    cyc = 0;
    int    nchk = 0;
    int    nerr = 0;
    int    exp_err_at = -1;
    string err_tag = "R9";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, expv);
        end
    endtask

    // Monitor: pop what is due this cycle and compare with the outputs.
    always @(negedge clk) begin : mon
        logic [N:0] e;
        logic [N:0] a;
        string      tag;
        if (!rst && !done) begin
            e = '0;
            while (sbq.size() > 0 && sbq[0].at <= cyc) begin
                if (sbq[0].at < cyc) chk(1'b0, "R2/R3/R4 missed", 32'(sbq[0].at), 32'(cyc));
                e |= sbq[0].bits;
                void'(sbq.pop_front());
            end
            a = {parent_ack, child_req};
            if (a[N] != e[N])      tag = "R4";
            else if (a[0] != e[0]) tag = "R2";
            else                   tag = "R3";
            chk(a == e, tag, 32'(a), 32'(e));
            chk($countones(a) <= 1, "R5", 32'(a), 32'(e));
            chk(err == (exp_err_at >= 0 && cyc >= exp_err_at), err_tag, 32'(err),
                32'(exp_err_at >= 0 && cyc >= exp_err_at));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
        parent_req = 1'b0;
        child_ack  = '0;
    endtask

    task automatic push(input int at, input int bitpos);
        exp_t x;
        x.at = at;
        x.bits = '0;
        x.bits[bitpos] = 1'b1;
        sbq.push_back(x);
    endtask

    task automatic mark_err(input string tag);
        if (exp_err_at < 0) begin
            exp_err_at = cyc + 1;
            err_tag = tag;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        // R1: everything low while and right after reset is applied
        chk({parent_ack, child_req, err} == '0, "R1", 32'({parent_ack, child_req, err}), 0);
        sbq.delete();
        exp_err_at = -1;
        err_tag = "R9";
        rst = 1'b0;
        step();
    endtask

    // inj: 0 none, 1 extra parent request (R6), 2 wrong child ack (R7),
    //      3 ack in the request cycle (R8). Injection happens in the cycle
    //      child request 0 is visible.
    task automatic do_txn(input int inj, input bit b2b);
        int lat[N];
        for (int k = 0; k < N; k++) lat[k] = $urandom_range(1, 4);
        parent_req = 1'b1;
        push(cyc + 1, 0);
        step();
        if (b2b) chk(child_req[0] == 1'b1, "R10", 32'(child_req), 1);
        case (inj)
            1: begin parent_req = 1'b1;   mark_err("R6"); end
            2: begin child_ack[N-1] = 1'b1; mark_err("R7"); end
            3: begin child_ack[0] = 1'b1;  mark_err("R8"); end
            default: ;
        endcase
        for (int k = 0; k < N; k++) begin
            repeat (lat[k]) step();
            child_ack[k] = 1'b1;
            push(cyc + 1, (k == N - 1) ? N : k + 1);
            step();
        end
    endtask

    initial begin
        do_reset();
        // R2 R3 R4 R5 R10: clean traffic with random latencies and gaps
        for (int t = 0; t < 14; t++) begin
            int gap;
            gap = $urandom_range(0, 2);
            do_txn(0, 1'b0);
            if (gap == 0) begin
                do_txn(0, 1'b1);
            end else begin
                repeat (gap) step();
            end
        end
        repeat (3) step();
        // R6 then R9: error must persist across clean transactions
        do_txn(1, 1'b0);
        step();
        do_txn(0, 1'b0);
        do_txn(0, 1'b1);
        repeat (3) step();
        do_reset();
        // R7: acknowledge from the wrong child
        do_txn(2, 1'b0);
        repeat (2) step();
        do_reset();
        // R8: acknowledge in the same cycle as the request
        do_txn(3, 1'b0);
        repeat (2) step();
        do_reset();
        // R7: acknowledge while idle changes no output
        child_ack[0] = 1'b1;
        mark_err("R7");
        step();
        repeat (3) step();
        do_txn(0, 1'b0);
        repeat (2) step();
        do_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            nerr++;
            nchk++;
            $display("FAIL watchdog R1..run actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule